// File: doc/BRIEF.md
# Task-Addressed Device Select

This block lets one peripheral that shares a multi-task bus recognise the task it serves. A 4-bit device address is loaded one bit at a time through an active-low serial input. The register keeps the address in inverted form, and its last stage drives an active-low serial output so that several devices can be chained. Two comparators check the stored value against the bus. A task match is raised when the current task number equals the complement of the stored value. An input match is raised when the upper nibble of the 8-bit input address equals that same complement.

Two ownership flags follow from these matches. The input flag has an active-low output. The output flag is active high. A bus-clock enable, explicit set strobes and a reset strobe update the flags. All state is clocked by one system clock. The shift, bus-clock and strobe inputs are single-cycle enables. An asynchronous active-low reset, released synchronously, clears the register and both flags.

Top module: `task_select`

## Requirements
- R1: While reset is applied and after it is released, the stored value is 0000, `ser_out_n` is 0, `in_me_n` is 1 and `out_me` is 0.
- R2: On a cycle with `shift_en` high, the level on `ser_in_n` enters bit 3 of the stored value and every other bit moves one place toward bit 0. `ser_out_n` always shows bit 0, so four shifts with `ser_in_n` at 0 leave `ser_out_n` at 0. Without `shift_en` the stored value holds.
- R3: `task_hit` is 1 exactly when `task_num` equals the bitwise complement of the stored value. For the other 15 task values it is 0.
- R4: `in_hit` is 1 exactly when `iaddr[7:4]` equals the complement of the stored value. `iaddr[3:0]` has no effect on it.
- R5: `in_set` on a cycle with `in_hit` high makes `in_me_n` read 0 after that edge.
- R6: `bus_clk_en` makes `in_me_n` read 1 after that edge, unless a qualified `in_set` (R5) occurs in the same cycle.
- R7: `out_set` on a cycle with `task_hit` high sets `out_me` to 1. `out_rst` clears it to 0 and wins over `out_set` in the same cycle.
- R8: `bus_clk_en` with `task_hit` low clears `out_me`. With `task_hit` high, `out_me` holds its value.
- R9: `in_set` while `in_hit` is low and `out_set` while `task_hit` is low have no effect on the flags.
- R10: After four shifts with `ser_in_n` at 1, the stored value is 1111. With `task_num` at 0 and `iaddr` at 0, both `task_hit` and `in_hit` read 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en | input | 1 | Shift enable for the address register |
| ser_in_n | input | 1 | Active-low serial address input |
| ser_out_n | output | 1 | Active-low serial output from the last stage |
| task_num | input | 4 | Current task number |
| iaddr | input | 8 | Input address bus |
| bus_clk_en | input | 1 | Bus clock edge enable |
| in_set | input | 1 | Input ownership set strobe |
| out_set | input | 1 | Output ownership set strobe |
| out_rst | input | 1 | Output ownership reset strobe |
| task_hit | output | 1 | Current task matches this device |
| in_hit | output | 1 | Input address upper nibble matches this device |
| in_me_n | output | 1 | Input ownership flag, active low |
| out_me | output | 1 | Output ownership flag |

## Verification
A block of ones is shifted through a cleared register, and then a block of zeros. Each pattern changes the matching task value in a different direction, so a stuck or swapped register bit or a comparator bit tied to the wrong stage shows up as a hit at the wrong task. At every step all 16 task values are swept, with the low input-address bits varied, to show that exactly one task matches and that the low nibble is ignored. On the matching task the flag set, clear, hold and priority sequences are run. On the other tasks, unqualified strobes and bus clocks show that nothing is set.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

  localparam int TSEL_ADDR_W  = 4;
  localparam int TSEL_IADDR_W = 8;

  typedef struct packed {
    logic bus;
    logic in_set;
    logic out_set;
    logic out_rst;
  } tsel_strobe_t;

endpackage

// File: rtl/tsel_rst_sync.sv
module tsel_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/tsel_addr_sreg.sv
module tsel_addr_sreg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         shift_en,
  input  logic         ser_in_n,
  output logic [W-1:0] addr_q,
  output logic         ser_out_n
);

  logic [W-1:0] addr_d;

  // Next state: the raw active-low level enters the top stage, so the
  // register holds the device address in inverted form.
  always_comb begin
    addr_d = addr_q;
    if (shift_en) begin
      addr_d = {ser_in_n, addr_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      addr_q <= '0;
    end else begin
      addr_q <= addr_d;
    end
  end

  assign ser_out_n = addr_q[0];

  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!arst_n)
    shift_en |=> addr_q[W-1] == $past(ser_in_n)); // R2

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!arst_n)
    shift_en |=> addr_q[W-2:0] == $past(addr_q[W-1:1])); // R2

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
    !shift_en |=> $stable(addr_q)); // R2

endmodule

// File: rtl/tsel_match.sv
module tsel_match #(
  parameter int ADDR_W  = 4,
  parameter int IADDR_W = 8
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic [ADDR_W-1:0]  addr_q,
  input  logic [ADDR_W-1:0]  task_num,
  input  logic [IADDR_W-1:0] iaddr,
  output logic               task_hit,
  output logic               in_hit
);

  localparam int LOW_W = IADDR_W - ADDR_W;

  logic [ADDR_W-1:0] task_bit_ok;
  logic [ADDR_W-1:0] iadr_bit_ok;

  // A bit agrees with the complement of the stored bit when the two differ.
  for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_bit
    assign task_bit_ok[gi] = task_num[gi] ^ addr_q[gi];
    assign iadr_bit_ok[gi] = iaddr[LOW_W + gi] ^ addr_q[gi];
  end

  assign task_hit = &task_bit_ok;
  assign in_hit   = &iadr_bit_ok;

  if (LOW_W > 0) begin : g_low_chk
    AST_LOW_IGNORED: assert property (@(posedge clk) disable iff (!arst_n)
      ($stable(addr_q) && $stable(iaddr[IADDR_W-1:LOW_W]) &&
       !$stable(iaddr[LOW_W-1:0])) |-> $stable(in_hit)); // R4
  end

endmodule

// File: rtl/tsel_own_flags.sv
module tsel_own_flags
  import tsel_pkg::*;
(
  input  logic         clk,
  input  logic         arst_n,
  input  tsel_strobe_t stb,
  input  logic         task_hit,
  input  logic         in_hit,
  output logic         in_flag_q,
  output logic         out_flag_q
);

  logic in_flag_d;
  logic out_flag_d;
  logic in_set_ok;
  logic out_set_ok;

  assign in_set_ok  = stb.in_set  & in_hit;
  assign out_set_ok = stb.out_set & task_hit;

  always_comb begin
    in_flag_d = in_flag_q;
    if (in_set_ok) begin
      in_flag_d = 1'b1;
    end else if (stb.bus) begin
      in_flag_d = 1'b0;
    end
  end

  always_comb begin
    out_flag_d = out_flag_q;
    if (stb.out_rst) begin
      out_flag_d = 1'b0;
    end else if (out_set_ok) begin
      out_flag_d = 1'b1;
    end else if (stb.bus && !task_hit) begin
      out_flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      in_flag_q  <= 1'b0;
      out_flag_q <= 1'b0;
    end else begin
      in_flag_q  <= in_flag_d;
      out_flag_q <= out_flag_d;
    end
  end

  AST_IN_SET: assert property (@(posedge clk) disable iff (!arst_n)
    (stb.in_set && in_hit) |=> in_flag_q); // R5

  AST_IN_BUS_CLR: assert property (@(posedge clk) disable iff (!arst_n)
    (stb.bus && !(stb.in_set && in_hit)) |=> !in_flag_q); // R6

  AST_OUT_RST: assert property (@(posedge clk) disable iff (!arst_n)
    stb.out_rst |=> !out_flag_q); // R7

  AST_OUT_BUS_MISS: assert property (@(posedge clk) disable iff (!arst_n)
    (stb.bus && !task_hit) |=> !out_flag_q); // R8

  AST_NO_STRAY_IN: assert property (@(posedge clk) disable iff (!arst_n)
    (!in_flag_q && !(stb.in_set && in_hit)) |=> !in_flag_q); // R9

  AST_NO_STRAY_OUT: assert property (@(posedge clk) disable iff (!arst_n)
    (!out_flag_q && !(stb.out_set && task_hit)) |=> !out_flag_q); // R9

endmodule

// File: rtl/task_select.sv
module task_select
  import tsel_pkg::*;
#(
  parameter int ADDR_W  = TSEL_ADDR_W,
  parameter int IADDR_W = TSEL_IADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               ser_in_n,
  output logic               ser_out_n,
  input  logic [ADDR_W-1:0]  task_num,
  input  logic [IADDR_W-1:0] iaddr,
  input  logic               bus_clk_en,
  input  logic               in_set,
  input  logic               out_set,
  input  logic               out_rst,
  output logic               task_hit,
  output logic               in_hit,
  output logic               in_me_n,
  output logic               out_me
);

  logic              arst_n;
  logic [ADDR_W-1:0] addr_q;
  logic              in_flag_q;
  logic              out_flag_q;
  tsel_strobe_t      stb;

  assign stb.bus     = bus_clk_en;
  assign stb.in_set  = in_set;
  assign stb.out_set = out_set;
  assign stb.out_rst = out_rst;

  tsel_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (arst_n)
  );

  tsel_addr_sreg #(.W(ADDR_W)) u_sreg (
    .clk       (clk),
    .arst_n    (arst_n),
    .shift_en  (shift_en),
    .ser_in_n  (ser_in_n),
    .addr_q    (addr_q),
    .ser_out_n (ser_out_n)
  );

  tsel_match #(.ADDR_W(ADDR_W), .IADDR_W(IADDR_W)) u_match (
    .clk      (clk),
    .arst_n   (arst_n),
    .addr_q   (addr_q),
    .task_num (task_num),
    .iaddr    (iaddr),
    .task_hit (task_hit),
    .in_hit   (in_hit)
  );

  tsel_own_flags u_flags (
    .clk        (clk),
    .arst_n     (arst_n),
    .stb        (stb),
    .task_hit   (task_hit),
    .in_hit     (in_hit),
    .in_flag_q  (in_flag_q),
    .out_flag_q (out_flag_q)
  );

  assign in_me_n = ~in_flag_q;
  assign out_me  = out_flag_q;

  AST_RESET_STATE: assert property (@(posedge clk)
    !arst_n |-> (in_me_n && !out_me && !ser_out_n)); // R1

endmodule

// File: tb/task_select_test.sv
`timescale 1ns/1ps
module task_select_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       shift_en, ser_in_n, bus_clk_en, in_set, out_set, out_rst;
  logic [3:0] task_num;
  logic [7:0] iaddr;
  logic       ser_out_n, task_hit, in_hit, in_me_n, out_me;

  int checks = 0;
  int errors = 0;
  int m_addr = 0;
  int m_in = 0;
  int m_out = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  task_select uut (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .ser_in_n(ser_in_n),
    .ser_out_n(ser_out_n), .task_num(task_num), .iaddr(iaddr),
    .bus_clk_en(bus_clk_en), .in_set(in_set), .out_set(out_set),
    .out_rst(out_rst), .task_hit(task_hit), .in_hit(in_hit),
    .in_me_n(in_me_n), .out_me(out_me)
  );

  task automatic chk(string req, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, nm, act, exp);
    end
  endtask

  function automatic int comp_addr();
    return (~m_addr) & 15;
  endfunction

  // One clock: advance the reference model at the edge, compare at the
  // falling edge, then drop the single-cycle strobes.
  task automatic step();
    int th, ih;
    @(posedge clk);
    th = (int'(task_num) == comp_addr());
    ih = ((int'(iaddr) >> 4) == comp_addr());
    if (in_set && ih) m_in = 1;
    else if (bus_clk_en) m_in = 0;
    if (out_rst) m_out = 0;
    else if (out_set && th) m_out = 1;
    else if (bus_clk_en && !th) m_out = 0;
    if (shift_en) m_addr = (m_addr >> 1) | (int'(ser_in_n) << 3);
    @(negedge clk);
    chk("R2", "ser_out_n", int'(ser_out_n), m_addr & 1);
    chk("R3", "task_hit", int'(task_hit), int'(int'(task_num) == comp_addr()));
    chk("R4", "in_hit", int'(in_hit), int'((int'(iaddr) >> 4) == comp_addr()));
    chk("R6", "in_me_n", int'(in_me_n), 1 - m_in);
    chk("R8", "out_me", int'(out_me), m_out);
    shift_en = 0; bus_clk_en = 0; in_set = 0; out_set = 0; out_rst = 0;
  endtask

  task automatic walk(bit lvl);
    for (int i = 0; i < 4; i++) begin
      shift_en = 1; ser_in_n = lvl; step();
      for (int j = 0; j < 16; j++) begin
        int c;
        c = comp_addr();
        task_num = 4'(j);
        iaddr = 8'((c << 4) | ((j * 5) & 15));
        step();
        if (j == c) begin
          chk("R3", "task_hit on own task", int'(task_hit), 1);
          bus_clk_en = 1; step();
          chk("R6", "in_me_n after bus", int'(in_me_n), 1);
          in_set = 1; step();
          chk("R5", "in_me_n after set", int'(in_me_n), 0);
          bus_clk_en = 1; step();
          chk("R6", "in_me_n cleared by bus", int'(in_me_n), 1);
          out_set = 1; step();
          chk("R7", "out_me after set", int'(out_me), 1);
          bus_clk_en = 1; step();
          chk("R8", "out_me holds on hit", int'(out_me), 1);
          out_set = 1; out_rst = 1; step();
          chk("R7", "out_rst priority", int'(out_me), 0);
          out_set = 1; step();
          task_num = 4'(j ^ 1); bus_clk_en = 1; step();
          chk("R8", "out_me cleared on miss", int'(out_me), 0);
          task_num = 4'(j);
        end else begin
          chk("R3", "task_hit off task", int'(task_hit), 0);
          out_set = 1; step();
          chk("R9", "out_set ignored", int'(out_me), 0);
          iaddr = 8'(((c ^ 1) << 4) | (j & 15));
          in_set = 1; step();
          chk("R9", "in_set ignored", int'(in_me_n), 1);
          bus_clk_en = 1; step();
          chk("R8", "bus on miss", int'(out_me), 0);
        end
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; shift_en = 0; ser_in_n = 1; bus_clk_en = 0; in_set = 0;
    out_set = 0; out_rst = 0; task_num = 4'd0; iaddr = 8'd0;
    repeat (3) @(negedge clk);
    chk("R1", "ser_out_n in reset", int'(ser_out_n), 0);
    chk("R1", "in_me_n in reset", int'(in_me_n), 1);
    chk("R1", "out_me in reset", int'(out_me), 0);
    rst_n = 1;
    repeat (4) step();
    chk("R1", "out_me after release", int'(out_me), 0);
    for (int i = 0; i < 4; i++) begin
      shift_en = 1; ser_in_n = 0; step();
    end
    chk("R2", "ser_out_n after clearing shifts", int'(ser_out_n), 0);
    walk(1'b1);
    walk(1'b0);
    for (int i = 0; i < 4; i++) begin
      shift_en = 1; ser_in_n = 1; step();
    end
    task_num = 4'd0; iaddr = 8'd0;
    step();
    chk("R10", "task_hit with all ones", int'(task_hit), 1);
    chk("R10", "in_hit with all ones", int'(in_hit), 1);
    chk("R10", "ser_out_n with all ones", int'(ser_out_n), 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule